// File: doc/BRIEF.md
# Subcode Q Frame Holding Register with Serial Host Readout

This block sits between a compact-disc subcode decoder and a host controller. Each decoded Q-channel frame arrives as 80 parallel bits together with a CRC result. A 16-bit level-meter word arrives with it. A frame that passes the acceptance test is copied into a 96-bit holding register, and a ready flag tells the host that valid position data is waiting. The host then shifts the register out on its own slow clock. The host's first falling clock edge freezes the register. The register stays frozen until the host pulses a read-complete line. That pulse clears the ready flag and lets new frames in again.

The acceptance test needs a good CRC. In address-1 mode it also needs the frame's ADR field to equal 1. In address-free mode the ADR condition is dropped. An 8-bit mode command selects between the two modes. The ready flag is held for a limited window of `WIN_CYC` system clocks. If the host starts no read in that window, the flag drops and loading carries on.

Control is a three-state machine:
- **IDLE**: ready low, loading enabled.
- **READY**: ready high, window counting, loading still enabled.
- **READ**: ready high, register frozen.

The transitions are:
- IDLE → READY on an accepted frame.
- READY → READY on an accepted frame, which reloads the register and restarts the window.
- READY → READ on the first accepted falling edge of the host clock.
- READY → IDLE on read-complete or when the window expires.
- READ → IDLE on read-complete.

Top module: `subq_latch_reader`

## Requirements
- R1: The ready flag rises only in the cycle after a frame strobe that has `crc_ok_i` high. In address-1 mode that frame must also have ADR, which is `qframe_i[75:72]`, equal to 4'd1. A frame with a bad CRC, or with a different ADR in address-1 mode, changes neither the flag nor the register.
- R2: A load of mode command 8'b0000_1001 selects address-free mode, where the ADR condition is dropped. A load of 8'b1000_1001 selects address-1 mode. Any other command value leaves the mode unchanged.
- R3: After reset the block is in address-1 mode, the ready flag is low and the serial line is low.
- R4: The first accepted falling edge of the host clock while ready is high freezes the holding register. Accepted frames that arrive before read-complete are discarded.
- R5: A read-complete pulse while ready is high drops the ready flag on the next clock edge and re-enables loading.
- R6: The ready flag stays high for exactly `WIN_CYC` system clocks after the last accepted frame unless a read starts. At expiry the flag drops and later frames load normally. An accepted frame inside the window reloads the register and restarts the window.
- R7: The 96 readout bits come out in this field sequence:
  - CONT = `qframe_i[79:76]`
  - ADR = `qframe_i[75:72]`
  - eight 8-bit fields from `qframe_i[71:64]` down to `qframe_i[15:8]`
  - the last 8-bit field, `qframe_i[7:0]`
  - the 16-bit meter word as one unit
- R8: With `msb_first_i` low, each field is sent starting from its least significant bit. With `msb_first_i` high, each field is sent starting from its most significant bit. The field sequence is the same for both settings.
- R9: The k-th accepted falling edge (k from 0) puts readout bit k on `sdata_o` within three system clocks, and it holds until the next falling edge. Falling edges after the 96th bit drive 0.
- R10: While `sel_i` is low, `sdata_o` is 0 and host clock edges neither freeze the register nor advance the bit position.
- R11: Host clock edges while the ready flag is low are ignored and do not advance the bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qframe_i | input | 80 | Decoded Q frame, CONT in the top nibble |
| qframe_vld_i | input | 1 | One-cycle strobe: a new frame is on `qframe_i` |
| crc_ok_i | input | 1 | CRC result for the strobed frame |
| meter_i | input | 16 | Level-meter word captured with the frame |
| mode_cmd_i | input | 8 | Mode command byte |
| mode_ld_i | input | 1 | One-cycle strobe loading `mode_cmd_i` |
| hclk_i | input | 1 | Host shift clock, asynchronous, idles high |
| msb_first_i | input | 1 | Bit order inside each field, 1 = MSB first |
| rd_done_i | input | 1 | Read-complete pulse from the host |
| sel_i | input | 1 | Chip select, active high |
| ready_o | output | 1 | Valid frame held and ready for reading |
| sdata_o | output | 1 | Serial readout data |

## Verification
The bench builds the block with `WIN_CYC` = 256 and two synchronizer stages.

A window of 256 clocks is far shorter than one full 96-bit readout, which takes about 1450 clocks. This brings several cases within reach in a short run:
- exact window expiry;
- a restart inside the window;
- a freeze that outlives the window.

Every bit position is checked against an arithmetic model of the field sequence. The bench sweeps four frame patterns under both bit orders, and it also checks bit position 96.

// File: rtl/subq_pkg.sv
package subq_pkg;

    localparam int Q_BITS    = 80;
    localparam int MTR_BITS  = 16;
    localparam int HOLD_BITS = Q_BITS + MTR_BITS;
    localparam int NFIELD    = 12;
    localparam int SHORT_W   = 4;
    localparam int BYTE_W    = 8;
    localparam int POS_W     = $clog2(HOLD_BITS + 1);
    localparam int ADR_HI    = Q_BITS - SHORT_W - 1;
    localparam int ADR_LO    = Q_BITS - 2 * SHORT_W;

    localparam logic [7:0] CMD_ADDR_FREE = 8'b0000_1001;
    localparam logic [7:0] CMD_ADDR_ONE  = 8'b1000_1001;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_READ  = 2'd2
    } rd_state_t;

    // width of field f in serial order
    function automatic int field_width(input int f);
        if (f < 2)               return SHORT_W;
        else if (f == NFIELD - 1) return MTR_BITS;
        else                      return BYTE_W;
    endfunction

    // readout bit p of the holding register, field order fixed, bit order per msb
    function automatic logic pick_bit(input logic [HOLD_BITS-1:0] h,
                                      input int p,
                                      input logic msb);
        int   start;
        int   w;
        int   hi;
        int   idx;
        logic res;
        start = 0;
        res   = 1'b0;
        for (int f = 0; f < NFIELD; f++) begin
            w = field_width(f);
            if (p >= start && p < start + w) begin
                hi  = HOLD_BITS - 1 - start;
                idx = msb ? (hi - (p - start)) : (hi - w + 1 + (p - start));
                res = h[idx];
            end
            start = start + w;
        end
        return res;
    endfunction

endpackage

// File: rtl/subq_hclk_sync.sv
module subq_hclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    always_comb fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/subq_mode_dec.sv
module subq_mode_dec
    import subq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_i,
    input  logic [7:0] cmd_i,
    output logic       addr_free_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_free_o <= 1'b0;
        end else if (ld_i) begin
            if (cmd_i == CMD_ADDR_FREE)     addr_free_o <= 1'b1;
            else if (cmd_i == CMD_ADDR_ONE) addr_free_o <= 1'b0;
        end
    end

endmodule

// File: rtl/subq_bit_sel.sv
module subq_bit_sel
    import subq_pkg::*;
(
    input  logic [HOLD_BITS-1:0] hold_i,
    input  logic [POS_W-1:0]     pos_i,
    input  logic                 msb_first_i,
    output logic                 bit_o
);
    always_comb begin
        if (int'(pos_i) < HOLD_BITS) bit_o = pick_bit(hold_i, int'(pos_i), msb_first_i);
        else                         bit_o = 1'b0;
    end

endmodule

// File: rtl/subq_latch_reader.sv
module subq_latch_reader
    import subq_pkg::*;
#(
    parameter int WIN_CYC     = 1400000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [Q_BITS-1:0]   qframe_i,
    input  logic                qframe_vld_i,
    input  logic                crc_ok_i,
    input  logic [MTR_BITS-1:0] meter_i,
    input  logic [7:0]          mode_cmd_i,
    input  logic                mode_ld_i,
    input  logic                hclk_i,
    input  logic                msb_first_i,
    input  logic                rd_done_i,
    input  logic                sel_i,
    output logic                ready_o,
    output logic                sdata_o
);
    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
    localparam logic [POS_W-1:0] POS_END  = POS_W'(HOLD_BITS);

    rd_state_t             state_q, state_d;
    logic [WIN_W-1:0]      win_cnt_q;
    logic [HOLD_BITS-1:0]  hold_q;
    logic [POS_W-1:0]      pos_q;
    logic                  out_q;
    logic                  addr_free;
    logic                  hfall;
    logic                  cur_bit;
    logic                  accept;
    logic                  shift_ev;
    logic                  load;

    subq_hclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (hclk_i),
        .fall_o  (hfall)
    );

    subq_mode_dec u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_i        (mode_ld_i),
        .cmd_i       (mode_cmd_i),
        .addr_free_o (addr_free)
    );

    subq_bit_sel u_sel (
        .hold_i      (hold_q),
        .pos_i       (pos_q),
        .msb_first_i (msb_first_i),
        .bit_o       (cur_bit)
    );

    // frame acceptance and host edge qualification
    always_comb begin
        accept   = qframe_vld_i & crc_ok_i &
                   (addr_free | (qframe_i[ADR_HI:ADR_LO] == 4'd1));
        shift_ev = hfall & sel_i & (state_q != ST_IDLE);
    end

    // next state
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_READY;
                    load    = 1'b1;
                end
            end
            ST_READY: begin
                if (rd_done_i) begin
                    state_d = ST_IDLE;
                end else if (shift_ev) begin
                    state_d = ST_READ;
                end else if (accept) begin
                    state_d = ST_READY;
                    load    = 1'b1;
                end else if (win_cnt_q == WIN_LAST) begin
                    state_d = ST_IDLE;
                end
            end
            ST_READ: begin
                if (rd_done_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            win_cnt_q <= '0;
            hold_q    <= '0;
            pos_q     <= '0;
            out_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) hold_q <= {qframe_i, meter_i};

            if (load || state_d != ST_READY) win_cnt_q <= '0;
            else                             win_cnt_q <= win_cnt_q + 1'b1;

            if (state_d == ST_IDLE || load) begin
                pos_q <= '0;
                out_q <= 1'b0;
            end else if (shift_ev) begin
                out_q <= cur_bit;
                if (pos_q != POS_END) pos_q <= pos_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_READY, ST_READ: ready_o = 1'b1;
            default:           ready_o = 1'b0;
        endcase
        sdata_o = sel_i ? out_q : 1'b0;
    end

endmodule

// File: rtl/subq_latch_reader_chk.sv
module subq_latch_reader_chk
    import subq_pkg::*;
#(
    parameter int WIN_CYC = 1400000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [Q_BITS-1:0]    qframe_i,
    input logic                 qframe_vld_i,
    input logic                 crc_ok_i,
    input logic [7:0]           mode_cmd_i,
    input logic                 mode_ld_i,
    input logic                 rd_done_i,
    input logic                 sel_i,
    input logic                 ready_o,
    input rd_state_t            state_q,
    input logic                 addr_free,
    input logic [HOLD_BITS-1:0] hold_q,
    input logic [POS_W-1:0]     pos_q
);
    int run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_READY || qframe_vld_i) run_q <= 0;
        else                                               run_q <= run_q + 1;
    end

    p_ready_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(qframe_vld_i && crc_ok_i &&
                                 (addr_free || qframe_i[ADR_HI:ADR_LO] == 4'd1)));

    p_cmd_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ld_i && mode_cmd_i == 8'b0000_1001) |=> addr_free);

    p_cmd_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ld_i && mode_cmd_i == 8'b1000_1001) |=> !addr_free);

    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && $past(state_q == ST_READ)) |-> $stable(hold_q));

    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done_i && state_q != ST_IDLE) |=> !ready_o);

    p_window_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY) |-> (run_q < WIN_CYC));

    p_pos_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pos_q) <= HOLD_BITS);

    p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && state_q == ST_READ && !rd_done_i) |=> $stable(pos_q));

    p_idle_pos_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (pos_q == '0));

endmodule

bind subq_latch_reader subq_latch_reader_chk #(.WIN_CYC(WIN_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .qframe_i     (qframe_i),
    .qframe_vld_i (qframe_vld_i),
    .crc_ok_i     (crc_ok_i),
    .mode_cmd_i   (mode_cmd_i),
    .mode_ld_i    (mode_ld_i),
    .rd_done_i    (rd_done_i),
    .sel_i        (sel_i),
    .ready_o      (ready_o),
    .state_q      (state_q),
    .addr_free    (addr_free),
    .hold_q       (hold_q),
    .pos_q        (pos_q)
);

// File: tb/subq_latch_reader_tb.sv
module subq_latch_reader_tb;

    localparam int WIN = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [79:0] qframe_i = '0;
    logic        qframe_vld_i = 1'b0;
    logic        crc_ok_i = 1'b0;
    logic [15:0] meter_i = '0;
    logic [7:0]  mode_cmd_i = '0;
    logic        mode_ld_i = 1'b0;
    logic        hclk_i = 1'b1;
    logic        msb_first_i = 1'b0;
    logic        rd_done_i = 1'b0;
    logic        sel_i = 1'b1;
    logic        ready_o;
    logic        sdata_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    subq_latch_reader #(.WIN_CYC(WIN), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .qframe_i(qframe_i), .qframe_vld_i(qframe_vld_i),
        .crc_ok_i(crc_ok_i), .meter_i(meter_i), .mode_cmd_i(mode_cmd_i),
        .mode_ld_i(mode_ld_i), .hclk_i(hclk_i), .msb_first_i(msb_first_i),
        .rd_done_i(rd_done_i), .sel_i(sel_i), .ready_o(ready_o), .sdata_o(sdata_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [79:0] mk_frame(input int k, input logic [3:0] adr);
        logic [23:0] s;
        s = 24'(k * 24'h5A3C1 + 24'h01F2D);
        return {4'(k + 3), adr, s, ~s, s ^ 24'hA5A5A5};
    endfunction

    function automatic logic [15:0] mk_meter(input int k);
        return 16'(k * 16'h1357 + 16'hBEEF);
    endfunction

    // expected serial bit p from the field sequence
    function automatic logic exp_bit(input logic [79:0] f, input logic [15:0] m,
                                     input int p, input logic msb);
        logic [95:0] all;
        logic [95:0] sh;
        int start;
        int w;
        int off;
        logic r;
        all = {f, m};
        start = 0;
        r = 1'b0;
        if (p >= 96) return 1'b0;
        for (int i = 0; i < 12; i++) begin
            w = (i < 2) ? 4 : ((i == 11) ? 16 : 8);
            if (p >= start && p < start + w) begin
                off = p - start;
                sh = all >> (96 - start - w);
                r = msb ? sh[w - 1 - off] : sh[off];
            end
            start = start + w;
        end
        return r;
    endfunction

    task automatic send_frame(input logic [79:0] f, input logic [15:0] m, input logic ok);
        @(negedge clk);
        qframe_i = f; meter_i = m; crc_ok_i = ok; qframe_vld_i = 1'b1;
        @(negedge clk);
        qframe_vld_i = 1'b0; crc_ok_i = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk);
        mode_cmd_i = c; mode_ld_i = 1'b1;
        @(negedge clk);
        mode_ld_i = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        rd_done_i = 1'b1;
        @(negedge clk);
        rd_done_i = 1'b0;
        chk("R5 ready after read-complete", int'(ready_o), 0);
    endtask

    task automatic shift_one(output logic b);
        @(negedge clk);
        hclk_i = 1'b0;
        repeat (6) @(negedge clk);
        b = sdata_o;
        hclk_i = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic read_range(input logic [79:0] f, input logic [15:0] m, input logic msb,
                              input int from, input int upto, input string req);
        logic b;
        msb_first_i = msb;
        for (int p = from; p <= upto; p++) begin
            shift_one(b);
            chk(req, int'(b), int'(exp_bit(f, m, p, msb)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic b;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 ready after reset", int'(ready_o), 0);
        chk("R3 sdata after reset", int'(sdata_o), 0);

        // R3/R1: address-1 mode after reset, ADR=2 rejected
        send_frame(mk_frame(9, 4'd2), mk_meter(9), 1'b1);
        chk("R1 ADR!=1 rejected in address-1 mode", int'(ready_o), 0);
        send_frame(mk_frame(9, 4'd1), mk_meter(9), 1'b0);
        chk("R1 bad CRC rejected", int'(ready_o), 0);

        // R11: host edges with ready low ignored
        for (int i = 0; i < 3; i++) begin
            shift_one(b);
            chk("R11 sdata with ready low", int'(b), 0);
        end

        // sweep: patterns x bit order, R7 R8 R9
        for (int k = 0; k < 4; k++) begin
            for (int o = 0; o < 2; o++) begin
                send_frame(mk_frame(k, 4'd1), mk_meter(k), 1'b1);
                chk("R1 accepted frame raises ready", int'(ready_o), 1);
                read_range(mk_frame(k, 4'd1), mk_meter(k), o[0], 0, 96, "R7 R8 R9 readout bit");
                done_pulse();
            end
        end

        // R4: freeze during read
        send_frame(mk_frame(5, 4'd1), mk_meter(5), 1'b1);
        read_range(mk_frame(5, 4'd1), mk_meter(5), 1'b0, 0, 19, "R4 readout before new frame");
        send_frame(mk_frame(6, 4'd1), mk_meter(6), 1'b1);
        read_range(mk_frame(5, 4'd1), mk_meter(5), 1'b0, 20, 96, "R4 frozen register");
        done_pulse();
        // R5: loading re-enabled
        send_frame(mk_frame(6, 4'd1), mk_meter(6), 1'b1);
        chk("R5 ready after reload", int'(ready_o), 1);
        read_range(mk_frame(6, 4'd1), mk_meter(6), 1'b1, 0, 96, "R5 new frame after release");
        done_pulse();

        // R2: mode commands
        send_cmd(8'h0A);
        send_frame(mk_frame(7, 4'd2), mk_meter(7), 1'b1);
        chk("R2 unknown command ignored", int'(ready_o), 0);
        send_cmd(8'b0000_1001);
        send_frame(mk_frame(7, 4'd2), mk_meter(7), 1'b1);
        chk("R2 address-free accepts ADR=2", int'(ready_o), 1);
        read_range(mk_frame(7, 4'd2), mk_meter(7), 1'b1, 0, 96, "R2 address-free readout");
        done_pulse();
        send_cmd(8'b1000_1001);
        send_frame(mk_frame(8, 4'd3), mk_meter(8), 1'b1);
        chk("R2 address-1 restored", int'(ready_o), 0);

        // R6: exact window
        send_frame(mk_frame(10, 4'd1), mk_meter(10), 1'b1);
        n = 0;
        while (ready_o && n < 2 * WIN) begin
            n++;
            @(negedge clk);
        end
        chk("R6 window length", n, WIN);
        // R6: restart inside window
        send_frame(mk_frame(11, 4'd1), mk_meter(11), 1'b1);
        repeat (40) @(negedge clk);
        send_frame(mk_frame(12, 4'd1), mk_meter(12), 1'b1);
        n = 0;
        while (ready_o && n < 2 * WIN) begin
            n++;
            @(negedge clk);
        end
        chk("R6 window restarted", n, WIN);
        // R6: updating continues after expiry
        send_frame(mk_frame(13, 4'd1), mk_meter(13), 1'b1);
        read_range(mk_frame(13, 4'd1), mk_meter(13), 1'b0, 0, 96, "R6 load after expiry");
        done_pulse();

        // R10: chip select low
        send_frame(mk_frame(14, 4'd1), mk_meter(14), 1'b1);
        sel_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            shift_one(b);
            chk("R10 sdata with select low", int'(b), 0);
        end
        send_frame(mk_frame(15, 4'd1), mk_meter(15), 1'b1);
        sel_i = 1'b1;
        read_range(mk_frame(15, 4'd1), mk_meter(15), 1'b0, 0, 96, "R10 no freeze or advance");
        done_pulse();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule